// File: doc/BRIEF.md
# Sound Channel Status Register

This block is the single processor-visible control and status register of a sound unit with four length-counted tone channels (two pulse, one triangle, one noise) and one sample-playback channel. A write latches the channel enables and produces one-cycle side-effect pulses toward the channels: counters of disabled channels are cleared, and sample playback is either stopped or restarted. A read returns a registered snapshot of channel activity and of the two interrupt flags, and it applies the read-to-clear rule to the frame flag only.

Bus accesses are sequenced by a three-state access machine. `ACC_IDLE` is the rest state. A write strobe moves it to `ACC_WR_FX` for one cycle, and in that state the clear, stop and restart pulses are driven. A read strobe moves it to `ACC_RD_RET` for one cycle, and in that state `rd_valid` is high with the captured word on `rd_data`. From every state the next state depends only on the strobes of the current cycle: write → `ACC_WR_FX`, read → `ACC_RD_RET`, neither → `ACC_IDLE`. Write and read are never asserted together. The frame and sample interrupt flags are set by input pulses, and a set always wins over a clear in the same cycle. `irq` is the OR of both flags.

Top module: `snd_status_reg`

## Requirements
- R1: After reset all enables, both interrupt flags, `irq`, `rd_valid`, `rd_data` and every pulse output are 0.
- R2: In the cycle after a write, `ch_enable[3:0]` equals `wr_data[3:0]` (bit 0 pulse 1, bit 1 pulse 2, bit 2 triangle, bit 3 noise) and `smp_enable` equals `wr_data[4]`. Bits 7 to 5 have no effect. Enables hold between writes.
- R3: In the cycle after a write, `len_clear[i]` is 1 for every channel written with enable 0. It is 0 in every other cycle.
- R4: In the cycle after a write with bit 4 = 0, `smp_stop` pulses for one cycle.
- R5: In the cycle after a write with bit 4 = 1, `smp_restart` pulses only if `smp_bytes_nz` was 0 in the write cycle. Otherwise neither sample pulse fires.
- R6: A write clears the sample interrupt flag, unless `smp_irq_set` is high in the same cycle.
- R7: A read returns, in the next cycle with `rd_valid` = 1, the word bit 7 = sample flag, bit 6 = frame flag, bit 5 = 0, bit 4 = `smp_bytes_nz`, bits 3..0 = `len_active`. Each value is taken in the read cycle, and a flag counts as set if its set pulse is high in that cycle. `rd_data` holds until the next read.
- R8: A read clears the frame interrupt flag.
- R9: A read never clears the sample interrupt flag.
- R10: If `frame_irq_set` is high in the read cycle, the read returns 1 in bit 6 and the frame flag stays set.
- R11: `irq` is high exactly while either interrupt flag is set.
- R12: A set pulse on `frame_irq_set` or `smp_irq_set` sets its flag from the next cycle on, and the flag holds until its clear condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read word |
| rd_valid | output | 1 | Read word valid (cycle after read) |
| len_active | input | 4 | Per-channel length counter non-zero |
| smp_bytes_nz | input | 1 | Sample bytes remaining non-zero |
| frame_irq_set | input | 1 | Frame interrupt set pulse |
| smp_irq_set | input | 1 | Sample interrupt set pulse |
| ch_enable | output | 4 | Tone channel enables |
| smp_enable | output | 1 | Sample playback enable |
| len_clear | output | 4 | One-cycle length counter clear per channel |
| smp_stop | output | 1 | One-cycle force of remaining byte count to 0 |
| smp_restart | output | 1 | One-cycle sample playback restart |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong access state shows one cycle after the strobe, as a missing or extra pulse on `len_clear`, `smp_stop`, `smp_restart` or `rd_valid`. A wrong enable register shows at once on `ch_enable`. A wrong interrupt flag shows on `irq` in the next cycle, and on bits 7 and 6 of the next read word. The reference model is compared on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/snd_stat_pkg.sv
package snd_stat_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_WR_FX  = 2'd1,
        ACC_RD_RET = 2'd2
    } acc_state_t;
endpackage

// File: rtl/snd_irq_flag.sv
module snd_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_req,
    output logic flag,
    output logic flag_view
);
    // set has priority over any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag <= 1'b0;
        else if (set_pulse)  flag <= 1'b1;
        else if (clr_req)    flag <= 1'b0;
    end

    // value a same-cycle read observes
    assign flag_view = flag | set_pulse;

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> flag);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/snd_access_fsm.sv
module snd_access_fsm
    import snd_stat_pkg::*;
#(
    parameter int NUM_LEN_CH = 4,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  smp_bytes_nz,
    output logic [NUM_LEN_CH-1:0] ch_enable,
    output logic                  smp_enable,
    output logic [NUM_LEN_CH-1:0] len_clear,
    output logic                  smp_stop,
    output logic                  smp_restart,
    output logic                  rd_valid
);
    localparam int SMP_BIT = NUM_LEN_CH;
    localparam int EN_W    = NUM_LEN_CH + 1;

    acc_state_t state_q, state_d;
    logic [EN_W-1:0] en_q;
    logic            nz_cap_q;

    always_comb begin
        if (wr_en)      state_d = ACC_WR_FX;
        else if (rd_en) state_d = ACC_RD_RET;
        else            state_d = ACC_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ACC_IDLE;
            en_q     <= '0;
            nz_cap_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                en_q     <= wr_data[EN_W-1:0];
                nz_cap_q <= smp_bytes_nz;
            end
        end
    end

    always_comb begin
        len_clear   = '0;
        smp_stop    = 1'b0;
        smp_restart = 1'b0;
        rd_valid    = 1'b0;
        unique case (state_q)
            ACC_IDLE: ;
            ACC_WR_FX: begin
                len_clear   = ~en_q[NUM_LEN_CH-1:0];
                smp_stop    = ~en_q[SMP_BIT];
                smp_restart = en_q[SMP_BIT] & ~nz_cap_q;
            end
            ACC_RD_RET: rd_valid = 1'b1;
            default: ;
        endcase
    end

    assign ch_enable  = en_q[NUM_LEN_CH-1:0];
    assign smp_enable = en_q[SMP_BIT];

    assert_no_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
    assert_clr_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_clear != '0) |-> $past(wr_en));
    assert_sample_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_stop && smp_restart));
    assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_en_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch_enable));
endmodule

// File: rtl/snd_read_capture.sv
module snd_read_capture #(
    parameter int NUM_LEN_CH = 4,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  smp_view,
    input  logic                  frame_view,
    input  logic                  smp_bytes_nz,
    input  logic [NUM_LEN_CH-1:0] len_active,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int NZ_BIT    = NUM_LEN_CH;
    localparam int FRAME_BIT = DATA_W - 2;
    localparam int SMPI_BIT  = DATA_W - 1;

    logic [DATA_W-1:0] word;

    always_comb begin
        word                   = '0;
        word[NUM_LEN_CH-1:0]   = len_active;
        word[NZ_BIT]           = smp_bytes_nz;
        word[FRAME_BIT]        = frame_view;
        word[SMPI_BIT]         = smp_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= word;
    end

    assert_frame_seen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && frame_view) |=> rd_data[FRAME_BIT]);
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-3] == 1'b0);
endmodule

// File: rtl/snd_status_reg.sv
module snd_status_reg #(
    parameter int NUM_LEN_CH = 4,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    input  logic [NUM_LEN_CH-1:0] len_active,
    input  logic                  smp_bytes_nz,
    input  logic                  frame_irq_set,
    input  logic                  smp_irq_set,
    output logic [NUM_LEN_CH-1:0] ch_enable,
    output logic                  smp_enable,
    output logic [NUM_LEN_CH-1:0] len_clear,
    output logic                  smp_stop,
    output logic                  smp_restart,
    output logic                  irq
);
    logic frame_flag, frame_view, smp_flag, smp_view;

    snd_access_fsm #(.NUM_LEN_CH(NUM_LEN_CH), .DATA_W(DATA_W)) u_fsm (
        .clk, .rst_n, .wr_en, .rd_en, .wr_data, .smp_bytes_nz,
        .ch_enable, .smp_enable, .len_clear, .smp_stop, .smp_restart, .rd_valid
    );

    // frame flag: cleared by a read
    snd_irq_flag u_frame (
        .clk, .rst_n, .set_pulse(frame_irq_set), .clr_req(rd_en),
        .flag(frame_flag), .flag_view(frame_view)
    );

    // sample flag: cleared by a write, untouched by reads
    snd_irq_flag u_smp (
        .clk, .rst_n, .set_pulse(smp_irq_set), .clr_req(wr_en),
        .flag(smp_flag), .flag_view(smp_view)
    );

    snd_read_capture #(.NUM_LEN_CH(NUM_LEN_CH), .DATA_W(DATA_W)) u_rd (
        .clk, .rst_n, .rd_en, .smp_view, .frame_view, .smp_bytes_nz,
        .len_active, .rd_data
    );

    assign irq = frame_flag | smp_flag;

    assert_read_keeps_smp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_flag && rd_en) |=> smp_flag);
    assert_write_clears_smp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !smp_irq_set) |=> !smp_flag);
    assert_read_clears_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !frame_irq_set) |=> !frame_flag);
    assert_irq_from_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq_set || smp_irq_set) |=> irq);
endmodule

// File: tb/tb_snd_status_reg.sv
module tb_snd_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [3:0] len_active = '0;
    logic       smp_bytes_nz = 1'b0;
    logic       frame_irq_set = 1'b0, smp_irq_set = 1'b0;
    logic [3:0] ch_enable, len_clear;
    logic       smp_enable, smp_stop, smp_restart, irq;

    int vectors = 0;
    int errors  = 0;
    bit run = 1'b0;

    always #2 clk = ~clk;

    snd_status_reg dut (
        .clk, .rst_n, .wr_en, .wr_data, .rd_en, .rd_data, .rd_valid,
        .len_active, .smp_bytes_nz, .frame_irq_set, .smp_irq_set,
        .ch_enable, .smp_enable, .len_clear, .smp_stop, .smp_restart, .irq
    );

    // behavioural reference model
    logic [4:0] m_en;
    logic       m_ff, m_sf, m_stop, m_rst, m_rdv;
    logic [3:0] m_lclr;
    logic [7:0] m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_ff = 0; m_sf = 0; m_stop = 0; m_rst = 0;
            m_rdv = 0; m_lclr = '0; m_rd = '0;
        end else begin
            m_lclr = wr_en ? ~wr_data[3:0] : 4'h0;
            m_stop = wr_en && !wr_data[4];
            m_rst  = wr_en && wr_data[4] && !smp_bytes_nz;
            m_rdv  = rd_en;
            if (rd_en)
                m_rd = {m_sf | smp_irq_set, m_ff | frame_irq_set, 1'b0,
                        smp_bytes_nz, len_active};
            if (frame_irq_set) m_ff = 1; else if (rd_en) m_ff = 0;
            if (smp_irq_set)   m_sf = 1; else if (wr_en) m_sf = 0;
            if (wr_en) m_en = wr_data[4:0];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            chk("R2 enables",   {3'b0, smp_enable, ch_enable}, {3'b0, m_en});
            chk("R3 len_clear", {4'b0, len_clear}, {4'b0, m_lclr});
            chk("R4 smp_stop",  {7'b0, smp_stop}, {7'b0, m_stop});
            chk("R5 restart",   {7'b0, smp_restart}, {7'b0, m_rst});
            chk("R7 rd_valid",  {7'b0, rd_valid}, {7'b0, m_rdv});
            chk("R7 rd_data",   rd_data, m_rd);
            chk("R11 irq",      {7'b0, irq}, {7'b0, m_ff | m_sf});
        end
    end

    // one clock: drive at negedge, return at next negedge with strobes dropped
    task automatic cyc(input bit w, input bit r, input logic [7:0] d,
                       input bit fs, input bit ss, input bit nz, input logic [3:0] act);
        wr_en = w; rd_en = r; wr_data = d; frame_irq_set = fs; smp_irq_set = ss;
        smp_bytes_nz = nz; len_active = act;
        @(negedge clk);
        wr_en = 0; rd_en = 0; frame_irq_set = 0; smp_irq_set = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {irq, rd_valid, smp_stop, smp_restart, smp_enable, ch_enable == 0, 2'b0},
            8'b0000_0100);
        chk("R1 reset rd_data", rd_data, 8'h00);
        run = 1'b1;

        // R2 upper bits ignored, R3 and R4 pulses
        cyc(1, 0, 8'hE5, 0, 0, 0, 4'h0);
        chk("R2 ch_enable", {4'b0, ch_enable}, 8'h05);
        chk("R3 clear 1010", {4'b0, len_clear}, 8'h0A);
        chk("R4 stop", {7'b0, smp_stop}, 8'h01);
        // R5 restart only with empty count
        cyc(1, 0, 8'h1F, 0, 0, 0, 4'h0);
        chk("R5 restart empty", {7'b0, smp_restart}, 8'h01);
        cyc(1, 0, 8'h1F, 0, 0, 1, 4'h0);
        chk("R5 no restart busy", {6'b0, smp_restart, smp_stop}, 8'h00);
        // R12 frame set; R8 read clears
        cyc(0, 0, 8'h00, 1, 0, 1, 4'h9);
        chk("R12 frame irq", {7'b0, irq}, 8'h01);
        cyc(0, 1, 8'h00, 0, 0, 1, 4'h9);
        chk("R7 read word", rd_data, 8'h59);
        cyc(0, 1, 8'h00, 0, 0, 0, 4'h3);
        chk("R8 frame cleared", rd_data, 8'h03);
        // R10 set during read wins
        cyc(0, 1, 8'h00, 1, 0, 0, 4'h0);
        chk("R10 same-cycle read", {7'b0, rd_data[6]}, 8'h01);
        chk("R10 flag kept", {7'b0, irq}, 8'h01);
        cyc(0, 1, 8'h00, 0, 0, 0, 4'h0);
        chk("R10 still set", {7'b0, rd_data[6]}, 8'h01);
        cyc(0, 1, 8'h00, 0, 0, 0, 4'h0);
        // R9 read keeps sample flag; R6 write clears it
        cyc(0, 0, 8'h00, 0, 1, 0, 4'h0);
        cyc(0, 1, 8'h00, 0, 0, 0, 4'h0);
        cyc(0, 1, 8'h00, 0, 0, 0, 4'h0);
        chk("R9 smp kept", rd_data, 8'h80);
        cyc(1, 0, 8'h00, 0, 0, 0, 4'h0);
        chk("R6 smp cleared", {7'b0, irq}, 8'h00);
        cyc(0, 1, 8'h00, 0, 0, 0, 4'h0);
        chk("R6 read after write", rd_data, 8'h00);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 3);
            cyc(op == 1, op == 2, 8'($urandom), 1'($urandom_range(0, 5) == 0),
                1'($urandom_range(0, 5) == 0), 1'($urandom), 4'($urandom));
        end

        run = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule